// File: doc/BRIEF.md
# DAC Command and Double-Buffered Register Unit

This unit sits behind a serial-bus front end that collects a 24-bit input word. When the front end has received all three bytes, it raises a one-cycle valid strobe. The unit reads a 4-bit operation code from the top nibble of the word. It then acts on a pair of registers: a holding register that takes new codes, and an output register that feeds the converter. It also keeps a sleep flag that tells the analog side to power down.

The unit accepts converter resolutions of 16, 14 or 12 bits. The code always sits left-justified in the 16-bit data field. Any low bits below the chosen resolution are forced to zero before they are stored. Both registers and the sleep flag change on the first rising clock edge after the strobe.

The operation codes are:

- `0000` loads the holding register.
- `0001` copies the holding register into the output register and wakes the converter.
- `0011` loads the new code and commits it in the same cycle.
- `0100` puts the converter to sleep.
- Every other code does nothing.

Top module: `dac_cmd_unit`

## Requirements
- R1: After synchronous reset, `dac_code` is 0, `sleep_out` is 0, and the holding register is 0. A commit issued right after reset therefore leaves `dac_code` at 0.
- R2: The operation code is read from `cmd_word[23:20]`. Bits 19..16 never change the result.
- R3: Operation `0000` loads `cmd_word[15:0]` (masked per R9) into the holding register. `dac_code` and `sleep_out` stay unchanged.
- R4: Operation `0001` copies the holding register into `dac_code` on the first rising edge after the strobe.
- R5: Operation `0001` clears `sleep_out`.
- R6: Operation `0011` places the masked `cmd_word[15:0]` of that same word into `dac_code` and into the holding register. The old holding value is not used. `sleep_out` is cleared.
- R7: Operation `0100` sets `sleep_out`. `dac_code` and the holding register stay unchanged.
- R8: Operation codes other than `0000`, `0001`, `0011` and `0100` change neither the registers nor `sleep_out`.
- R9: With parameter `RES_BITS` set to 16, 14 or 12, the lowest 16-`RES_BITS` bits of every stored code are zero. Other parameter values are rejected at elaboration.
- R10: While `cmd_valid` is low, `dac_code` and `sleep_out` hold their values, whatever `cmd_word` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | One-cycle strobe: a complete 24-bit word is present |
| cmd_word | input | 24 | Operation in [23:20], unused [19:16], left-justified code in [15:0] |
| dac_code | output | 16 | Output-register code driven to the converter |
| sleep_out | output | 1 | High while the converter is commanded to power down |

## Verification
Every result, whether a load, a commit, a sleep or an ignored word, is due on the first rising edge after the cycle in which `cmd_valid` is high. No operation has a longer latency.

The driver pushes one expected item for every clock cycle it drives, whether or not the strobe is high. The monitor pops one item 1 ns after each rising edge and compares it with `dac_code` and `sleep_out` at that moment. This catches a result that arrives a cycle early, a cycle late, or on a cycle with no strobe.

The holding register has no port of its own. Its contents are checked through a later commit.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;

    localparam int WORD_W = 24;
    localparam int CODE_W = 16;
    localparam int OP_W   = 4;
    localparam int OP_LSB = WORD_W - OP_W;

    typedef enum logic [OP_W-1:0] {
        OP_LOAD        = 4'b0000,
        OP_COMMIT      = 4'b0001,
        OP_LOAD_COMMIT = 4'b0011,
        OP_SLEEP       = 4'b0100
    } op_e;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic  load;
        logic  commit;
        logic  sleep;
        code_t code;
    } action_t;

    // Mask that keeps the top res bits of a left-justified code.
    function automatic code_t keep_mask(input int res);
        code_t one;
        one = code_t'(1);
        return ~((one << (CODE_W - res)) - one);
    endfunction

    function automatic logic res_legal(input int res);
        return (res == 16) || (res == 14) || (res == 12);
    endfunction

    function automatic action_t decode_op(input logic [OP_W-1:0] op,
                                          input code_t           code);
        action_t a;
        a.load   = 1'b0;
        a.commit = 1'b0;
        a.sleep  = 1'b0;
        a.code   = code;
        case (op)
            OP_LOAD:        a.load   = 1'b1;
            OP_COMMIT:      a.commit = 1'b1;
            OP_LOAD_COMMIT: begin
                a.load   = 1'b1;
                a.commit = 1'b1;
            end
            OP_SLEEP:       a.sleep  = 1'b1;
            default:        ;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/dacreg_decode.sv
module dacreg_decode
    import dacreg_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic              valid,
    input  logic [WORD_W-1:0] word,
    output action_t           act
);
    localparam code_t MASK = keep_mask(RES_BITS);

    logic [OP_W-1:0] op;
    code_t           raw_code;
    action_t         decoded;

    assign op       = word[WORD_W-1:OP_LSB];
    assign raw_code = word[CODE_W-1:0];

    generate
        if (!res_legal(RES_BITS)) begin : g_bad_res
            initial $error("dacreg_decode: RES_BITS must be 16, 14 or 12");
        end
    endgenerate

    always_comb begin
        decoded = decode_op(op, raw_code & MASK);
        act     = decoded;
        if (!valid) begin
            act.load   = 1'b0;
            act.commit = 1'b0;
            act.sleep  = 1'b0;
        end
    end
endmodule

// File: rtl/dacreg_hold_stage.sv
module dacreg_hold_stage
    import dacreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  code_t new_code,
    output code_t held_code
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_code <= '0;
        end else if (load) begin
            held_code <= new_code;
        end
    end
endmodule

// File: rtl/dacreg_out_stage.sv
module dacreg_out_stage
    import dacreg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  logic  commit,
    input  logic  sleep,
    input  code_t new_code,
    input  code_t held_code,
    output code_t out_code,
    output logic  asleep
);
    code_t src_code;

    // The combined operation forwards the fresh code, bypassing the hold stage.
    always_comb begin
        src_code = (load && commit) ? new_code : held_code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_code <= '0;
            asleep   <= 1'b0;
        end else begin
            if (commit) begin
                out_code <= src_code;
                asleep   <= 1'b0;
            end else if (sleep) begin
                asleep   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/dac_cmd_unit.sv
module dac_cmd_unit
    import dacreg_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [23:0] cmd_word,
    output logic [15:0] dac_code,
    output logic        sleep_out
);
    action_t act;
    code_t   held_code;
    code_t   out_code;
    logic    asleep;

    dacreg_decode #(.RES_BITS(RES_BITS)) u_decode (
        .valid (cmd_valid),
        .word  (cmd_word),
        .act   (act)
    );

    dacreg_hold_stage u_hold (
        .clk       (clk),
        .rst       (rst),
        .load      (act.load),
        .new_code  (act.code),
        .held_code (held_code)
    );

    dacreg_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .load      (act.load),
        .commit    (act.commit),
        .sleep     (act.sleep),
        .new_code  (act.code),
        .held_code (held_code),
        .out_code  (out_code),
        .asleep    (asleep)
    );

    assign dac_code  = out_code;
    assign sleep_out = asleep;
endmodule

// File: rtl/dac_cmd_unit_chk.sv
module dac_cmd_unit_chk
    import dacreg_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [23:0] cmd_word,
    input logic [15:0] dac_code,
    input logic        sleep_out,
    input logic [15:0] held_code
);
    localparam code_t MASK = keep_mask(RES_BITS);

    logic [3:0] op;
    assign op = cmd_word[23:20];

    // R1: reset clears the output code and the sleep flag
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (dac_code == 16'h0 && !sleep_out));

    // R3: a load leaves the output register untouched
    assert_load_keeps_out_R3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == 4'b0000) |=> ($stable(dac_code) && $stable(sleep_out)));

    // R4: a commit moves the holding value to the output
    assert_commit_copies_R4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == 4'b0001) |=> (dac_code == $past(held_code)));

    // R5: a commit wakes the converter
    assert_commit_wakes_R5: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == 4'b0001) |=> !sleep_out);

    // R6: the combined operation forwards the fresh code
    assert_combined_fresh_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == 4'b0011) |=>
            (dac_code == ($past(cmd_word[15:0]) & MASK) && !sleep_out));

    // R7: sleep sets the flag and keeps the code
    assert_sleep_sets_R7: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op == 4'b0100) |=> (sleep_out && $stable(dac_code)));

    // R8: unknown codes change nothing
    assert_unknown_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && op != 4'b0000 && op != 4'b0001 && op != 4'b0011 && op != 4'b0100)
            |=> ($stable(dac_code) && $stable(sleep_out) && $stable(held_code)));

    // R9: stored codes never carry bits below the resolution
    assert_low_bits_zero_R9: assert property (@(posedge clk) disable iff (rst)
        ((dac_code & ~MASK) == 16'h0) && ((held_code & ~MASK) == 16'h0));

    // R10: no strobe, no change
    assert_idle_stable_R10: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> ($stable(dac_code) && $stable(sleep_out)));
endmodule

bind dac_cmd_unit dac_cmd_unit_chk #(.RES_BITS(RES_BITS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .dac_code  (dac_code),
    .sleep_out (sleep_out),
    .held_code (held_code)
);

// File: tb/dac_cmd_unit_tb.sv
module dac_cmd_unit_tb;
    localparam int RES = 12;
    localparam logic [15:0] MASK = 16'hFFF0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [23:0] cmd_word = '0;
    logic [15:0] dac_code;
    logic        sleep_out;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    typedef struct {
        logic [15:0] code;
        logic        pd;
        string       tag;
    } exp_t;

    exp_t exp_q[$];

    logic [15:0] m_hold = '0;
    logic [15:0] m_out  = '0;
    logic        m_pd   = 1'b0;

    always #4 clk = ~clk;

    dac_cmd_unit #(.RES_BITS(RES)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .dac_code  (dac_code),
        .sleep_out (sleep_out)
    );

    task automatic push(input string tag);
        exp_t e;
        e.code = m_out;
        e.pd   = m_pd;
        e.tag  = tag;
        exp_q.push_back(e);
    endtask

    // Drive one word for one cycle and predict the result.
    task automatic send(input logic [3:0] op, input logic [3:0] dc,
                        input logic [15:0] data, input string tag);
        logic [15:0] d;
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = {op, dc, data};
        d = data & MASK;
        case (op)
            4'b0000: m_hold = d;
            4'b0001: begin m_out = m_hold; m_pd = 1'b0; end
            4'b0011: begin m_hold = d; m_out = d; m_pd = 1'b0; end
            4'b0100: m_pd = 1'b1;
            default: ;
        endcase
        push(tag);
    endtask

    // Idle cycles with a noisy word on the bus.
    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_valid = 1'b0;
            cmd_word  = 24'h15A5A5 ^ (24'h3C3C3 * i);
            push(tag);
        end
    endtask

    // Monitor: one expected item per driven cycle, sampled after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (dac_code !== e.code || sleep_out !== e.pd) begin
                    errors++;
                    $display("FAIL %s: got code=%h pd=%b expected code=%h pd=%b",
                             e.tag, dac_code, sleep_out, e.code, e.pd);
                end
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (dac_code !== 16'h0 || sleep_out !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got code=%h pd=%b expected code=0000 pd=0",
                     dac_code, sleep_out);
        end
        rst = 1'b0;
        idle(2, "R1 idle after reset");
        send(4'b0001, 4'h0, 16'h0000, "R1 commit of cleared hold");
        send(4'b0000, 4'h0, 16'hA5A7, "R3 load keeps output");
        send(4'b0001, 4'h0, 16'hFFFF, "R4 commit copies hold");
        send(4'b0000, 4'hF, 16'h1234, "R2 don't-care nibble set");
        send(4'b0001, 4'hA, 16'h0000, "R2 commit with nibble set");
        send(4'b0100, 4'h0, 16'h9999, "R7 sleep keeps code");
        send(4'b0000, 4'h0, 16'hBEEF, "R3 load while asleep");
        send(4'b0010, 4'h0, 16'h1111, "R8 code 0010 ignored");
        send(4'b0101, 4'h0, 16'h2222, "R8 code 0101 ignored");
        send(4'b1000, 4'h0, 16'h3333, "R8 code 1000 ignored");
        send(4'b1111, 4'h0, 16'h4444, "R8 code 1111 ignored");
        idle(3, "R10 no strobe");
        send(4'b0001, 4'h0, 16'h0000, "R5 commit wakes, R9 masked BEE0");
        send(4'b0000, 4'h0, 16'h5555, "R6 preload old hold");
        send(4'b0011, 4'h0, 16'hCAFE, "R6 combined uses fresh code");
        send(4'b0100, 4'h0, 16'h0000, "R7 sleep again");
        send(4'b0011, 4'h5, 16'h000F, "R6 combined wakes, R9 low bits dropped");
        send(4'b0000, 4'h0, 16'h7FFF, "R3 back-to-back load");
        send(4'b0001, 4'h0, 16'h0000, "R4 back-to-back commit");
        idle(2, "R10 final idle");
        @(negedge clk);
        cmd_valid = 1'b0;
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule